// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Sequencer

This block moves a 16-bit or 32-bit register value to or from a byte-wide peripheral whose registers sit on every second byte address. A start command carries a 2-bit mode, a base address and the current register contents. The block then runs one byte-wide bus cycle at a time, at addresses spaced two apart, starting with the most significant byte.

Each bus cycle is a request held until the target answers with an acknowledge or an abort. An abort ends the transfer at once. A 1-cycle pulse reports the outcome: done if the transfer completed, aborted if it did not. The register value to write back is presented with that pulse.

The command input follows valid/ready rules. `cmd_ready` is high only while the block is idle. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. A source may hold `cmd_valid` high for as long as it likes while the block is busy. Nothing is taken in those cycles, and the command fields may change freely. The bus side is a plain request/acknowledge handshake. It has no back-pressure beyond the wait for the answer.

Top module: `altbyte_xfer`

## Requirements
- R1: `cmd_ready` is 1 exactly when no transfer is in progress. A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both 1. A `cmd_valid` seen while busy changes nothing at the ports.
- R2: `cmd_mode` bit 1 selects the direction and bit 0 selects the size. The encodings are: 0 = word read, 1 = long read, 2 = word write, 3 = long write. `bus_we` equals bit 1 of the accepted mode during every cycle of the transfer.
- R3: Byte k of a transfer uses address base + 2k. A long transfer uses k = 0..3 and a word transfer uses k = 0..1. The address width wraps modulo 2^AW.
- R4: Writes put out the most significant byte first. For a word this is `cmd_reg[15:8]` then `[7:0]`. For a long it is `[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`.
- R5: A read assembles the value by shifting left 8 bits and ORing in each new byte. A long read replaces all 32 bits of `res_reg`. A word read returns `cmd_reg[31:16]` in the upper half and the two bytes read in the lower half. A completed write returns `cmd_reg` unchanged.
- R6: Only one byte cycle is outstanding at a time. `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold steady until a cycle with `bus_ack` or `bus_abort`. The next byte is presented in the cycle after the acknowledge.
- R7: A cycle with `bus_req` and `bus_abort` ends the transfer, and abort wins over a simultaneous `bus_ack`. No further request is issued. One cycle later `res_abort` pulses for one cycle and `res_reg` equals `cmd_reg`.
- R8: One cycle after the acknowledge of the final byte, `res_done` pulses for one cycle and `res_reg` holds the result. `res_done` and `res_abort` are never high together.
- R9: After reset: `cmd_ready` = 1, `bus_req` = 0, `res_done` = 0, `res_abort` = 0 and `res_reg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mode | input | 2 | Bit 1 direction (1 = write), bit 0 size (1 = long) |
| cmd_base | input | AW (24) | Address of the first byte |
| cmd_reg | input | DW (32) | Current register value |
| bus_req | output | 1 | Byte cycle requested |
| bus_addr | output | AW (24) | Byte address |
| bus_we | output | 1 | 1 = write cycle |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Byte cycle completed |
| bus_abort | input | 1 | Byte cycle failed |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |
| res_reg | output | DW (32) | Register value to write back |
| res_done | output | 1 | 1-cycle pulse: transfer completed |
| res_abort | output | 1 | 1-cycle pulse: transfer aborted |

## Verification
Two events can fall on the same edge: the acknowledge that completes a byte and an abort that cancels the transfer. The case that matters most is when both arrive on the final byte, so either a done or an abort pulse could follow. The bench answers bus requests with a random mix of acknowledge only, abort only, and both together, so the double case lands on first, middle and last bytes of all four modes. A behavioural model treats abort as dominant. It is compared every cycle on the request lines, the pulse chosen and the returned register value, which must be the unchanged `cmd_reg` and never a half-assembled read.

// File: rtl/altb_pkg.sv
package altb_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_BUS} altb_state_e;

  // Mode bit 1: direction (1 = register to peripheral)
  function automatic logic mode_is_write(input logic [1:0] m);
    return m[1];
  endfunction

  // Mode bit 0: size (1 = long)
  function automatic logic mode_is_long(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/altb_addr_gen.sv
module altb_addr_gen #(
  parameter int AW     = 24,
  parameter int NB     = 4,
  parameter int STRIDE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [AW-1:0]          base,
  input  logic                   is_long,
  input  logic                   step,
  output logic [AW-1:0]          addr,
  output logic [$clog2(NB)-1:0]  idx,
  output logic                   last
);
  localparam int IW = $clog2(NB);
  localparam int WB = NB / 2;

  logic [AW-1:0] base_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base;
      idx_q  <= '0;
    end else if (step && !last) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx  = idx_q;
  assign addr = base_q + AW'(idx_q) * AW'(STRIDE);
  assign last = is_long ? (idx_q == IW'(NB - 1)) : (idx_q == IW'(WB - 1));

  // R3
  addr_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !load) |=> (addr == $past(addr) + AW'(STRIDE)));
endmodule

// File: rtl/altb_byte_path.sv
module altb_byte_path #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [DW-1:0]                 reg_in,
  input  logic                          is_long,
  input  logic [$clog2(DW/BW)-1:0]      idx,
  input  logic                          shift,
  input  logic [BW-1:0]                 rdata,
  output logic [BW-1:0]                 wdata,
  output logic [DW-1:0]                 reg_q,
  output logic [DW-1:0]                 read_result
);
  localparam int NB = DW / BW;
  localparam int IW = $clog2(NB);
  localparam int WB = NB / 2;
  localparam int WW = WB * BW;

  logic [DW-1:0] reg_r;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] acc_nxt;
  logic [IW-1:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_r <= '0;
      acc_q <= '0;
    end else if (load) begin
      reg_r <= reg_in;
      acc_q <= '0;
    end else if (shift) begin
      acc_q <= acc_nxt;
    end
  end

  // Most significant byte first: byte slot counts down from the top
  assign sel     = (is_long ? IW'(NB - 1) : IW'(WB - 1)) - idx;
  assign wdata   = reg_r[sel*BW +: BW];
  assign acc_nxt = {acc_q[DW-BW-1:0], rdata};
  assign reg_q   = reg_r;

  generate
    if (DW > WW) begin : g_merge
      assign read_result = is_long ? acc_nxt : {reg_r[DW-1:WW], acc_nxt[WW-1:0]};
    end else begin : g_full
      assign read_result = acc_nxt;
    end
  endgenerate
endmodule

// File: rtl/altbyte_xfer.sv
module altbyte_xfer #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_mode,
  input  logic [AW-1:0] cmd_base,
  input  logic [DW-1:0] cmd_reg,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [BW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic          bus_abort,
  input  logic [BW-1:0] bus_rdata,
  output logic [DW-1:0] res_reg,
  output logic          res_done,
  output logic          res_abort
);
  import altb_pkg::*;

  localparam int NB = DW / BW;
  localparam int IW = $clog2(NB);

  altb_state_e   state_q;
  logic          write_q, long_q;
  logic          accept, byte_ok, byte_fail, finish;
  logic [IW-1:0] idx;
  logic          last;
  logic [DW-1:0] reg_q, read_result;
  logic          done_q, abort_q;
  logic [DW-1:0] res_q;

  assign cmd_ready = (state_q == ST_IDLE);
  assign bus_req   = (state_q == ST_BUS);
  assign bus_we    = write_q;
  assign accept    = cmd_valid && cmd_ready;
  // Abort dominates a simultaneous acknowledge
  assign byte_fail = bus_req && bus_abort;
  assign byte_ok   = bus_req && bus_ack && !bus_abort;
  assign finish    = byte_ok && last;

  altb_addr_gen #(.AW(AW), .NB(NB), .STRIDE(2)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(cmd_base),
    .is_long(long_q), .step(byte_ok), .addr(bus_addr), .idx(idx), .last(last)
  );

  altb_byte_path #(.DW(DW), .BW(BW)) u_data (
    .clk(clk), .rst_n(rst_n), .load(accept), .reg_in(cmd_reg),
    .is_long(long_q), .idx(idx), .shift(byte_ok && !write_q),
    .rdata(bus_rdata), .wdata(bus_wdata), .reg_q(reg_q),
    .read_result(read_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      long_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q  <= finish;
      abort_q <= byte_fail;
      if (accept) begin
        state_q <= ST_BUS;
        write_q <= mode_is_write(cmd_mode);
        long_q  <= mode_is_long(cmd_mode);
      end else if (byte_fail) begin
        state_q <= ST_IDLE;
        res_q   <= reg_q;
      end else if (finish) begin
        state_q <= ST_IDLE;
        res_q   <= write_q ? reg_q : read_result;
      end
    end
  end

  assign res_done  = done_q;
  assign res_abort = abort_q;
  assign res_reg   = res_q;

  // R1
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bus_req && bus_addr == $past(cmd_base)));
  // R6
  hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_abort) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));
  // R7
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_abort) |=> (!bus_req && res_abort && !res_done));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_done && res_abort));
endmodule

// File: tb/sim_altbyte_xfer.sv
module sim_altbyte_xfer;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_mode = '0;
  logic [AW-1:0] cmd_base = '0;
  logic [DW-1:0] cmd_reg = '0;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_ack = 1'b0, bus_abort = 1'b0;
  logic [7:0]    bus_rdata = '0;
  logic [DW-1:0] res_reg;
  logic          res_done, res_abort;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  altbyte_xfer #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_reg(cmd_reg),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_abort(bus_abort), .bus_rdata(bus_rdata),
    .res_reg(res_reg), .res_done(res_done), .res_abort(res_abort)
  );

  // Behavioural reference: queue of pending byte cycles
  logic [AW-1:0] q_addr[$];
  logic [7:0]    q_wd[$];
  logic          m_we = 1'b0;
  logic [1:0]    m_mode = '0;
  logic [DW-1:0] m_reg = '0, m_acc = '0, m_res = '0;
  logic          m_done = 1'b0, m_abt = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_addr.delete(); q_wd.delete();
      m_done = 1'b0; m_abt = 1'b0; m_res = '0;
    end else begin
      m_done = 1'b0; m_abt = 1'b0;
      if (q_addr.size() > 0) begin
        if (bus_abort) begin
          q_addr.delete(); q_wd.delete();
          m_abt = 1'b1; m_res = m_reg;
        end else if (bus_ack) begin
          if (!m_we) m_acc = (m_acc << 8) | DW'(bus_rdata);
          void'(q_addr.pop_front()); void'(q_wd.pop_front());
          if (q_addr.size() == 0) begin
            m_done = 1'b1;
            if (m_we) m_res = m_reg;
            else if (m_mode[0]) m_res = m_acc;
            else m_res = {m_reg[31:16], m_acc[15:0]};
          end
        end
      end else if (cmd_valid) begin
        m_mode = cmd_mode; m_we = cmd_mode[1]; m_reg = cmd_reg; m_acc = '0;
        for (int k = 0; k < (cmd_mode[0] ? 4 : 2); k++) begin
          q_addr.push_back(cmd_base + AW'(2 * k));
          q_wd.push_back(8'(cmd_reg >> (8 * ((cmd_mode[0] ? 3 : 1) - k))));
        end
      end
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic busy;
    busy = (q_addr.size() > 0);
    chk("R1 cmd_ready", DW'(cmd_ready), DW'(!busy));
    chk("R6 bus_req", DW'(bus_req), DW'(busy));
    if (busy) begin
      chk("R3 bus_addr", DW'(bus_addr), DW'(q_addr[0]));
      chk("R2 bus_we", DW'(bus_we), DW'(m_we));
      if (m_we) chk("R4 bus_wdata", DW'(bus_wdata), DW'(q_wd[0]));
    end
    chk("R8 res_done", DW'(res_done), DW'(m_done));
    chk("R7 res_abort", DW'(res_abort), DW'(m_abt));
    chk("R5 res_reg", res_reg, m_res);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    int r;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 cmd_ready", DW'(cmd_ready), 1);
    chk("R9 bus_req", DW'(bus_req), 0);
    chk("R9 res_done", DW'(res_done), 0);
    chk("R9 res_abort", DW'(res_abort), 0);
    chk("R9 res_reg", res_reg, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      compare_all();
      // R1: valid is offered often, including while busy
      cmd_valid = ($urandom_range(0, 2) != 0);
      cmd_mode  = 2'($urandom_range(0, 3));
      cmd_base  = AW'($urandom);
      if (cyc % 97 == 0) cmd_base = {AW{1'b1}} - AW'(1);  // R3 wrap
      cmd_reg   = $urandom;
      bus_rdata = 8'($urandom);
      r = $urandom_range(0, 99);
      // R7: abort alone, and abort with ack in the same cycle
      bus_ack   = (r < 60) || (r >= 90);
      bus_abort = (r >= 84);
    end
    @(negedge clk);
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule